// File: doc/BRIEF.md
# Embedded Erase and Program Sequencer

This block is the algorithm engine behind a flash array's write commands. Once a command front end has decoded a program or erase request, the engine runs the whole operation without further help. For a program it applies a pulse of fixed length to one location, reads the location back and repeats until the data matches or a pulse budget runs out. For an erase it first programs every location to zero, checking each one. It then alternates timed erase pulses with a blank check that scans upward and halts at the first location that is not yet all ones.

The array is reached through three narrow channels: a program pulse enable with address and data, an erase pulse enable, and a read request/acknowledge pair. While an operation runs, the host sees a busy flag and a polled status bit that reads as the inverse of the top data bit of the value being written. When the operation ends, the status bit shows that bit's true value. Failure to converge within the pulse budget raises a sticky error flag. Loss of the supply-good input stops any operation at once and returns the engine to its idle read state.

Top module: `flash_algo_seq`

## Requirements
- R1: After reset, busy, err_flag, pgm_en, ers_en and rd_req are 0 and poll_bit is 1.
- R2: An accepted start_prog raises busy on the next cycle, drives pgm_en for exactly PROG_PULSE_CYC (default 10) cycles with pgm_addr = cmd_addr and pgm_data = cmd_data, then issues a read of that address; the operation ends with busy low when the read data equals cmd_data.
- R3: A program repeats the pulse-and-read pair while the read data mismatches; after PROG_MAX_TRY (default 25) pulses without a match it sets err_flag and drops busy.
- R4: An erase first programs every address in ascending order, 0 up to the last, to all zeros, each with its own read check and the R3 pulse budget, before ers_en rises for the first time.
- R5: Each erase pulse holds ers_en high for exactly ERASE_PULSE_CYC (default 100) cycles. A blank check follows that reads addresses upward and stops at the first one whose data is not all ones; the next pulse then runs and the check resumes at that address. The erase ends when the last address reads all ones.
- R6: After ERASE_MAX_TRY (default 1000) erase pulses in one operation without a full blank check, err_flag is set and busy drops.
- R7: While busy, poll_bit equals the inverse of the target bit 7 (cmd_data bit 7 for a program, 1 for an erase); while idle it equals that target bit.
- R8: err_flag stays set through idle cycles and is cleared only by the next accepted start.
- R9: When supply_ok is low at a clock edge, busy, pgm_en, ers_en and rd_req are 0 after that edge, and err_flag is not set by the abort.
- R10: A start is accepted only while idle with supply_ok high; starts while busy or with supply_ok low have no effect; if start_erase and start_prog are both high, an erase runs.
- R11: At most one of pgm_en, ers_en and rd_req is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply good; low aborts and blocks starts |
| start_prog | input | 1 | One-cycle request to program one location |
| start_erase | input | 1 | One-cycle request to erase the whole array |
| cmd_addr | input | ADDR_W | Address of a program request |
| cmd_data | input | DATA_W | Data of a program request |
| busy | output | 1 | Operation in progress |
| poll_bit | output | 1 | Data-polling status bit |
| err_flag | output | 1 | Sticky convergence failure |
| pgm_en | output | 1 | Program pulse enable to the array |
| pgm_addr | output | ADDR_W | Program pulse address |
| pgm_data | output | DATA_W | Program pulse data |
| ers_en | output | 1 | Erase pulse enable to the array |
| rd_req | output | 1 | Read request to the array |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge, data valid this cycle |
| rd_data | input | DATA_W | Read data |

## Verification
The hardest situation to reach is a blank check that halts at an address in the middle of the array and then resumes there after another pulse. From the ports this only happens if the array responds differently per location. The bench's array model therefore carries a per-location count of erase pulses needed before the cell goes blank, with one stubborn location in the middle. Counting the reads across the whole erase then shows whether each check stopped at that location and resumed from it, rather than restarting from zero. Per-location program pulse counts similarly force retries and budget exhaustion.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PGM_PULSE,
      ST_PGM_READ,
      ST_ERS_PULSE,
      ST_ERS_READ
   } seq_state_t;

   typedef enum logic {
      OP_PROGRAM,
      OP_ERASE
   } seq_op_t;
endpackage

// File: rtl/seq_pulse_timer.sv
module seq_pulse_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] len,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt + 1'b1;
      else          cnt <= '0;
   end

   assign done = run && (cnt == len - 1'b1);
endmodule

// File: rtl/seq_try_counter.sv
module seq_try_counter #(
   parameter int LIMIT = 25,
   parameter int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             at_limit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (clr)  count <= '0;
      else if (inc)  count <= count + 1'b1;
   end

   assign at_limit = (count == CNT_W'(LIMIT));
endmodule

// File: rtl/seq_addr_walker.sv
module seq_addr_walker #(
   parameter int ADDR_W = 4,
   parameter bit RESUME = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic              rewind,
   output logic [ADDR_W-1:0] addr,
   output logic              at_last
);
   logic [ADDR_W-1:0] rewind_val;

   generate
      if (RESUME) begin : g_resume
         assign rewind_val = addr;
      end else begin : g_restart
         assign rewind_val = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr <= '0;
      else if (load)    addr <= load_val;
      else if (rewind)  addr <= rewind_val;
      else if (step)    addr <= addr + 1'b1;
   end

   assign at_last = &addr;
endmodule

// File: rtl/flash_algo_seq.sv
module flash_algo_seq
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W          = 4,
   parameter int DATA_W          = 8,
   parameter int PROG_PULSE_CYC  = 10,
   parameter int ERASE_PULSE_CYC = 100,
   parameter int PROG_MAX_TRY    = 25,
   parameter int ERASE_MAX_TRY   = 1000,
   parameter bit VERIFY_RESUME   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic              start_prog,
   input  logic              start_erase,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              busy,
   output logic              poll_bit,
   output logic              err_flag,
   output logic              pgm_en,
   output logic [ADDR_W-1:0] pgm_addr,
   output logic [DATA_W-1:0] pgm_data,
   output logic              ers_en,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data
);
   localparam int MAX_PULSE = (PROG_PULSE_CYC > ERASE_PULSE_CYC) ? PROG_PULSE_CYC : ERASE_PULSE_CYC;
   localparam int TIMER_W   = $clog2(MAX_PULSE + 1);
   localparam int PTRY_W    = $clog2(PROG_MAX_TRY + 1);
   localparam int ETRY_W    = $clog2(ERASE_MAX_TRY + 1);
   localparam int POLL_IDX  = DATA_W - 1;

   initial begin : g_param_chk
      assert (ADDR_W >= 1 && ADDR_W <= 16) else $error("ADDR_W out of range");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (PROG_PULSE_CYC >= 1 && ERASE_PULSE_CYC >= 1) else $error("pulse lengths must be positive");
      assert (PROG_MAX_TRY >= 1 && ERASE_MAX_TRY >= 1) else $error("try limits must be positive");
   end

   seq_state_t        state, state_nx;
   seq_op_t           op;
   logic [DATA_W-1:0] target;
   logic              start_ok;
   logic              tmr_run, tmr_done;
   logic [TIMER_W-1:0] tmr_len;
   logic              rd_match, rd_blank;
   logic              pre_adv, pre_fin, pgm_fail, ers_adv, ers_retry, ers_fail;
   logic              walk_load, walk_step, walk_rewind, at_last;
   logic [ADDR_W-1:0] walk_addr, walk_load_val;
   logic              ptry_clr, ptry_inc, ptry_lim;
   logic              etry_inc, etry_lim;
   logic [PTRY_W-1:0] ptry_cnt;
   logic [ETRY_W-1:0] etry_cnt;

   assign start_ok = (state == ST_IDLE) && supply_ok && (start_prog || start_erase);

   // pulse timer shared by both pulse kinds
   assign tmr_run = (state == ST_PGM_PULSE) || (state == ST_ERS_PULSE);
   assign tmr_len = (state == ST_ERS_PULSE) ? TIMER_W'(ERASE_PULSE_CYC) : TIMER_W'(PROG_PULSE_CYC);

   seq_pulse_timer #(.CNT_W(TIMER_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(tmr_run), .len(tmr_len), .done(tmr_done)
   );

   // read-back decisions
   assign rd_match  = (rd_data == pgm_data);
   assign rd_blank  = &rd_data;
   assign pre_adv   = (state == ST_PGM_READ) && rd_ack && rd_match && (op == OP_ERASE) && !at_last;
   assign pre_fin   = (state == ST_PGM_READ) && rd_ack && rd_match && (op == OP_ERASE) && at_last;
   assign pgm_fail  = (state == ST_PGM_READ) && rd_ack && !rd_match && ptry_lim;
   assign ers_adv   = (state == ST_ERS_READ) && rd_ack && rd_blank && !at_last;
   assign ers_retry = (state == ST_ERS_READ) && rd_ack && !rd_blank && !etry_lim;
   assign ers_fail  = (state == ST_ERS_READ) && rd_ack && !rd_blank && etry_lim;

   // address walker
   assign walk_load     = start_ok || pre_fin;
   assign walk_load_val = (start_ok && !start_erase) ? cmd_addr : '0;
   assign walk_step     = pre_adv || ers_adv;
   assign walk_rewind   = ers_retry;

   seq_addr_walker #(.ADDR_W(ADDR_W), .RESUME(VERIFY_RESUME)) u_walker (
      .clk(clk), .rst_n(rst_n), .load(walk_load), .load_val(walk_load_val),
      .step(walk_step), .rewind(walk_rewind), .addr(walk_addr), .at_last(at_last)
   );

   // pulse budgets
   assign ptry_clr = start_ok || pre_adv || pre_fin;
   assign ptry_inc = (state == ST_PGM_PULSE) && tmr_done;
   assign etry_inc = (state == ST_ERS_PULSE) && tmr_done;

   seq_try_counter #(.LIMIT(PROG_MAX_TRY), .CNT_W(PTRY_W)) u_ptry (
      .clk(clk), .rst_n(rst_n), .clr(ptry_clr), .inc(ptry_inc),
      .count(ptry_cnt), .at_limit(ptry_lim)
   );

   seq_try_counter #(.LIMIT(ERASE_MAX_TRY), .CNT_W(ETRY_W)) u_etry (
      .clk(clk), .rst_n(rst_n), .clr(start_ok), .inc(etry_inc),
      .count(etry_cnt), .at_limit(etry_lim)
   );

   // sequencing
   always_comb begin
      state_nx = state;
      if (!supply_ok) begin
         state_nx = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE:      if (start_ok) state_nx = ST_PGM_PULSE;
            ST_PGM_PULSE: if (tmr_done) state_nx = ST_PGM_READ;
            ST_PGM_READ:
               if (rd_ack) begin
                  if (rd_match)
                     state_nx = (op == OP_PROGRAM) ? ST_IDLE :
                                (at_last ? ST_ERS_PULSE : ST_PGM_PULSE);
                  else
                     state_nx = ptry_lim ? ST_IDLE : ST_PGM_PULSE;
               end
            ST_ERS_PULSE: if (tmr_done) state_nx = ST_ERS_READ;
            ST_ERS_READ:
               if (rd_ack) begin
                  if (rd_blank)
                     state_nx = at_last ? ST_IDLE : ST_ERS_READ;
                  else
                     state_nx = etry_lim ? ST_IDLE : ST_ERS_PULSE;
               end
            default:      state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op       <= OP_PROGRAM;
         target   <= '1;
         err_flag <= 1'b0;
      end else begin
         state <= state_nx;
         if (start_ok) begin
            op       <= start_erase ? OP_ERASE : OP_PROGRAM;
            target   <= start_erase ? '1 : cmd_data;
            err_flag <= 1'b0;
         end else if (supply_ok && (pgm_fail || ers_fail)) begin
            err_flag <= 1'b1;
         end
      end
   end

   // outputs
   assign busy     = (state != ST_IDLE);
   assign pgm_en   = (state == ST_PGM_PULSE);
   assign ers_en   = (state == ST_ERS_PULSE);
   assign rd_req   = (state == ST_PGM_READ) || (state == ST_ERS_READ);
   assign pgm_addr = walk_addr;
   assign rd_addr  = walk_addr;
   assign pgm_data = (op == OP_ERASE) ? '0 : target;
   assign poll_bit = busy ? ~target[POLL_IDX] : target[POLL_IDX];

   // pulse run length monitors for the checks below
   logic [TIMER_W:0] pgm_run, ers_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pgm_run <= '0;
         ers_run <= '0;
      end else begin
         pgm_run <= pgm_en ? pgm_run + 1'b1 : '0;
         ers_run <= ers_en ? ers_run + 1'b1 : '0;
      end
   end

   a_r11_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pgm_en, ers_en, rd_req}));

   a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !busy && !pgm_en && !ers_en && !rd_req);

   a_r2_prog_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pgm_en) && $past(supply_ok) |-> pgm_run == (TIMER_W+1)'(PROG_PULSE_CYC));

   a_r5_erase_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ers_en) && $past(supply_ok) |-> ers_run == (TIMER_W+1)'(ERASE_PULSE_CYC));

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !start_ok |=> err_flag);

   a_r7_poll_erase: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (op == OP_ERASE) |-> !poll_bit);

   a_r3_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ptry_cnt <= PTRY_W'(PROG_MAX_TRY));

   a_r6_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
      etry_cnt <= ETRY_W'(ERASE_MAX_TRY));
endmodule

// File: tb/flash_algo_seq_bench.sv
module flash_algo_seq_bench;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int NLOC = 1 << AW;
   localparam int PPC = 10;
   localparam int EPC = 100;
   localparam int PMAX = 25;
   localparam int EMAX = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b1;
   logic start_prog = 1'b0, start_erase = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic busy, poll_bit, err_flag, pgm_en, ers_en, rd_req;
   logic [AW-1:0] pgm_addr, rd_addr;
   logic [DW-1:0] pgm_data;
   logic rd_ack = 1'b0;
   logic [DW-1:0] rd_data = '0;

   always #10 clk = ~clk;

   flash_algo_seq #(
      .ADDR_W(AW), .DATA_W(DW), .PROG_PULSE_CYC(PPC), .ERASE_PULSE_CYC(EPC),
      .PROG_MAX_TRY(PMAX), .ERASE_MAX_TRY(EMAX), .VERIFY_RESUME(1'b1)
   ) u_flash_algo_seq (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .start_prog(start_prog),
      .start_erase(start_erase), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .busy(busy), .poll_bit(poll_bit), .err_flag(err_flag), .pgm_en(pgm_en),
      .pgm_addr(pgm_addr), .pgm_data(pgm_data), .ers_en(ers_en), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
   );

   // array model
   logic [DW-1:0] mem [NLOC];
   int prog_need [NLOC];
   int prog_seen [NLOC];
   int ers_need [NLOC];
   int ers_seen [NLOC];
   int n_pgm, n_ers, n_rd, pw, ew, last_pw, last_ew, pre_next;
   bit pre_order_ok;
   logic pgm_en_d = 1'b0, ers_en_d = 1'b0;

   always @(posedge clk) begin
      if (pgm_en && !pgm_en_d) begin
         n_pgm = n_pgm + 1;
         if (n_ers == 0) begin
            if (int'(pgm_addr) != pre_next) pre_order_ok = 1'b0;
            pre_next = pre_next + 1;
         end
         prog_seen[pgm_addr] = prog_seen[pgm_addr] + 1;
         if (prog_seen[pgm_addr] >= prog_need[pgm_addr]) mem[pgm_addr] = mem[pgm_addr] & pgm_data;
      end
      if (ers_en && !ers_en_d) begin
         n_ers = n_ers + 1;
         for (int a = 0; a < NLOC; a++) begin
            ers_seen[a] = ers_seen[a] + 1;
            if (ers_seen[a] >= ers_need[a]) mem[a] = '1;
         end
      end
      if (pgm_en) pw = pw + 1; else if (pw != 0) begin last_pw = pw; pw = 0; end
      if (ers_en) ew = ew + 1; else if (ew != 0) begin last_ew = ew; ew = 0; end
      if (rd_req && !rd_ack) begin
         rd_ack  <= 1'b1;
         rd_data <= mem[rd_addr];
         n_rd = n_rd + 1;
      end else begin
         rd_ack <= 1'b0;
      end
      pgm_en_d <= pgm_en;
      ers_en_d <= ers_en;
   end

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic reset_model(input int pneed, input int eneed);
      for (int a = 0; a < NLOC; a++) begin
         prog_need[a] = pneed; prog_seen[a] = 0;
         ers_need[a] = eneed;  ers_seen[a] = 0;
      end
      n_pgm = 0; n_ers = 0; n_rd = 0; pre_next = 0; pre_order_ok = 1'b1;
      last_pw = 0; last_ew = 0;
   endtask

   task automatic pulse_start(input bit prog, input bit erase, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      start_prog = prog; start_erase = erase; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      start_prog = 1'b0; start_erase = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (busy && n < 20000) begin @(negedge clk); n++; end
      check(!busy, req, busy, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(!busy, "R1 busy", busy, 0);
      check(!err_flag, "R1 err", err_flag, 0);
      check(!pgm_en && !ers_en && !rd_req, "R1 channels", {pgm_en, ers_en, rd_req}, 0);
      check(poll_bit, "R1 poll", poll_bit, 1);
   endtask

   task automatic t_program_once;
      reset_model(1, 1);
      for (int a = 0; a < NLOC; a++) mem[a] = '1;
      pulse_start(1'b1, 1'b0, 4'd3, 8'h5A);
      check(busy, "R2 busy after start", busy, 1);
      check(poll_bit == 1'b1, "R7 poll while busy", poll_bit, 1);
      wait_idle("R2 completes");
      check(n_pgm == 1, "R2 pulse count", n_pgm, 1);
      check(last_pw == PPC, "R2 pulse width", last_pw, PPC);
      check(mem[3] == 8'h5A, "R2 data written", mem[3], 8'h5A);
      check(n_rd == 1, "R2 read count", n_rd, 1);
      check(poll_bit == 1'b0, "R7 poll when done", poll_bit, 0);
      check(!err_flag, "R2 no error", err_flag, 0);
   endtask

   task automatic t_program_retry;
      reset_model(3, 1);
      mem[7] = '1;
      pulse_start(1'b1, 1'b0, 4'd7, 8'hA5);
      check(poll_bit == 1'b0, "R7 poll inverse of bit7", poll_bit, 0);
      wait_idle("R3 retry completes");
      check(n_pgm == 3, "R3 pulses until match", n_pgm, 3);
      check(n_rd == 3, "R3 verify per pulse", n_rd, 3);
      check(mem[7] == 8'hA5, "R3 data written", mem[7], 8'hA5);
      check(poll_bit == 1'b1, "R7 true bit7 when done", poll_bit, 1);
   endtask

   task automatic t_program_fail;
      reset_model(30, 1);
      mem[9] = '1;
      pulse_start(1'b1, 1'b0, 4'd9, 8'h00);
      wait_idle("R3 fail ends");
      check(n_pgm == PMAX, "R3 pulse budget", n_pgm, PMAX);
      check(err_flag, "R3 err set", err_flag, 1);
      repeat (5) @(negedge clk);
      check(err_flag, "R8 err sticky", err_flag, 1);
   endtask

   task automatic t_erase_resume;
      reset_model(1, 1);
      ers_need[5] = 3;
      for (int a = 0; a < NLOC; a++) mem[a] = 8'h3C;
      pulse_start(1'b0, 1'b1, '0, '0);
      @(negedge clk);
      check(!err_flag, "R8 err cleared by start", err_flag, 0);
      check(poll_bit == 1'b0, "R7 poll during erase", poll_bit, 0);
      wait_idle("R5 erase completes");
      check(n_pgm == NLOC, "R4 pre-program pulses", n_pgm, NLOC);
      check(pre_order_ok, "R4 ascending pre-program", pre_order_ok, 1);
      check(n_ers == 3, "R5 erase pulses", n_ers, 3);
      check(last_ew == EPC, "R5 erase width", last_ew, EPC);
      check(n_rd == NLOC + 18, "R5 resume reads", n_rd, NLOC + 18);
      begin
         int blank = 1;
         for (int a = 0; a < NLOC; a++) if (mem[a] != 8'hFF) blank = 0;
         check(blank == 1, "R5 array blank", blank, 1);
      end
      check(!err_flag && poll_bit, "R7 erase done poll", poll_bit, 1);
   endtask

   task automatic t_erase_fail;
      reset_model(1, 1);
      ers_need[0] = 99;
      pulse_start(1'b0, 1'b1, '0, '0);
      wait_idle("R6 fail ends");
      check(n_ers == EMAX, "R6 erase budget", n_ers, EMAX);
      check(n_rd == NLOC + EMAX, "R6 verify stops at first", n_rd, NLOC + EMAX);
      check(err_flag, "R6 err set", err_flag, 1);
   endtask

   task automatic t_abort;
      int n = 0;
      reset_model(1, 1);
      pulse_start(1'b0, 1'b1, '0, '0);
      while (!ers_en && n < 5000) begin @(negedge clk); n++; end
      supply_ok = 1'b0;
      @(negedge clk);
      check(!busy, "R9 busy cleared", busy, 0);
      check(!ers_en && !pgm_en && !rd_req, "R9 channels idle", {pgm_en, ers_en, rd_req}, 0);
      check(!err_flag, "R9 no error", err_flag, 0);
      reset_model(1, 1);
      pulse_start(1'b1, 1'b0, 4'd1, 8'h00);
      repeat (3) @(negedge clk);
      check(!busy && n_pgm == 0, "R10 ignored without supply", n_pgm, 0);
      supply_ok = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_start_rules;
      reset_model(1, 1);
      mem[2] = '1;
      pulse_start(1'b1, 1'b0, 4'd2, 8'h33);
      pulse_start(1'b0, 1'b1, '0, '0);
      wait_idle("R10 program done");
      check(n_pgm == 1 && n_ers == 0, "R10 start ignored while busy", n_ers, 0);
      check(mem[2] == 8'h33, "R10 program unaffected", mem[2], 8'h33);
      reset_model(1, 1);
      pulse_start(1'b1, 1'b1, 4'd4, 8'h11);
      wait_idle("R10 both starts done");
      check(n_ers == 1 && n_pgm == NLOC, "R10 erase wins", n_ers, 1);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      reset_model(1, 1);
      for (int a = 0; a < NLOC; a++) mem[a] = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program_once();
      t_program_retry();
      t_program_fail();
      t_erase_resume();
      t_erase_fail();
      t_abort();
      t_start_rules();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule